// File: doc/BRIEF.md
# Entropy Word Collector with Seed-Fault Recovery

This block is the control and status core of a hardware random number generator. Raw entropy arrives one bit at a time on an input port, with a strobe that marks each valid bit. A built-in linear feedback shift register can take the place of that port when a test needs a source that never stalls. The core packs the bits into 32-bit words at a rate set by a power-of-two clock divider, raises a data-ready flag, and hands the word out through a data register on a small 32-bit register bus. Clock errors are reported when the sample strobe stops arriving, and a seed-fault input halts generation.

A seed fault is recovered in one of two ways, chosen by a build parameter. In automatic mode the core clears its current fault flag by itself after a few cycles and resumes collection. In the other mode software runs a conditional reset: it writes the reset bit as one, then as zero, and waits until the bit clears by itself. The write that sets the reset bit is also the only access that can change the configuration fields, and a sticky lock bit can freeze those fields until the next hardware reset.

Registers, decoded from `bus_addr[4:2]`: control at byte offset 0x00, status at 0x04, data at 0x08, noise-source control at 0x0C, health-test control at 0x10.

Top module: `trng_ctrl`

## Requirements
- R1: After reset, control reads 0x0000_0000, status reads 0x0000_0000, noise control reads 0x0000_0000 and health control reads 0x0000_0040.
- R2: Accepted bits are packed so that the first bit lands in bit 31 of the word; when 32 bits are gathered, status bit 0 (data-ready) goes to 1 and a read of the data register returns the word and clears status bit 0.
- R3: One bit is accepted per 2^d bus cycles, where d is control bits 19:16.
- R4: Control bit 5 and bits 25:8 change only on a control write that also has bit 30 set, and they read back at the same positions.
- R5: Writing control bit 31 as 1 sets a lock that holds until hardware reset; while locked, control bits 5 and 25:8 keep their value on every write.
- R6: Control bit 30 reads 1 from a write of 1 until RST_CYCLES cycles after the following write of 0, then reads 0; during that whole time no bit is accepted and all gathered bits and data are discarded.
- R7: A seed fault while enabled sets status bits 2 (current seed fault) and 6 (seed-fault flag), clears data-ready, makes the data register read 0 and stops bit collection.
- R8: With AUTO_RESET=0, status bit 2 stays 1 until a conditional reset has completed, then clears; status bit 6 is left set.
- R9: With AUTO_RESET=1, status bit 2 clears by itself AUTO_CYCLES cycles after the fault, status bit 6 stays set and collection restarts from an empty word.
- R10: Status bits 5 and 6 clear only when software writes 0 to them; writing 1 leaves them unchanged, and writes do not alter status bits 0 to 2.
- R11: With control bit 5 set and the core enabled, a gap of health-control bits 15:0 bus cycles without a sample strobe sets status bits 1 (current clock error) and 5 (clock-error flag); the next strobe clears bit 1; with control bit 5 clear neither bit is set.
- R12: Only bits 17:0 of noise control are stored; bit 17 set selects the internal LFSR source, which supplies a bit on every divided tick with no external strobe.
- R13: With control bit 2 (enable) clear, no bit is accepted and data-ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ent_bit | input | 1 | Raw entropy bit |
| ent_valid | input | 1 | Sample strobe qualifying ent_bit |
| seed_fault | input | 1 | Injected seed-fault indication from the health tests |

## Verification
The properties assume that a seed fault never arrives on the same edge at which a conditional reset completes and that software does not re-arm the reset bit in that same cycle; the stimulus only pulses the fault with no reset sequence in flight. They also take the bus as one access per cycle with read data sampled after the edge, which the driver tasks keep by spacing every access a full cycle apart. Two instances, one per recovery mode, receive identical stimulus so each mode is observed under the same bus traffic.

// File: rtl/trng_pkg.sv
package trng_pkg;

   // register index taken from bus_addr[4:2]
   localparam logic [2:0] IDX_CTRL   = 3'd0;
   localparam logic [2:0] IDX_STAT   = 3'd1;
   localparam logic [2:0] IDX_DATA   = 3'd2;
   localparam logic [2:0] IDX_NOISE  = 3'd3;
   localparam logic [2:0] IDX_HEALTH = 3'd4;

   // control bits
   localparam int CR_EN     = 2;
   localparam int CR_CLKCHK = 5;
   localparam int CR_DIV_LO = 16;
   localparam int CR_RST    = 30;
   localparam int CR_LOCK   = 31;
   localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;

   // status bits
   localparam int SR_RDY     = 0;
   localparam int SR_CLK_NOW = 1;
   localparam int SR_SEED_NOW = 2;
   localparam int SR_CLK_FLG = 5;
   localparam int SR_SEED_FLG = 6;

   // noise-source control
   localparam int NOISE_W = 18;
   localparam int NOISE_INT_SRC = 17;

endpackage

// File: rtl/trng_source.sv
module trng_source #(
   parameter bit HAS_LFSR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_int,
   input  logic ext_bit,
   input  logic ext_valid,
   input  logic step,
   output logic bit_o,
   output logic valid_o
);
   localparam int LW = 32;
   localparam logic [LW-1:0] TAPS = 32'h8020_0003;
   localparam logic [LW-1:0] SEED = 32'h1ACE_5EED;

   generate
      if (HAS_LFSR) begin : g_lfsr
         logic [LW-1:0] state;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state <= SEED;
            end else if (use_int && step) begin
               state <= {1'b0, state[LW-1:1]} ^ (state[0] ? TAPS : '0);
            end
         end
         assign bit_o   = use_int ? state[0] : ext_bit;
         assign valid_o = use_int | ext_valid;
      end else begin : g_ext
         logic unused_src;
         assign unused_src = use_int ^ step ^ clk ^ rst_n;
         assign bit_o   = ext_bit;
         assign valid_o = ext_valid;
      end
   endgenerate
endmodule

// File: rtl/trng_gather.sv
module trng_gather #(
   parameter int W     = 32,
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             flush,
   input  logic [DIV_W-1:0] div,
   input  logic             in_bit,
   input  logic             in_valid,
   input  logic             take,
   output logic [W-1:0]     word,
   output logic             ready,
   output logic             step
);
   localparam int DC_W = (1 << DIV_W) - 1;
   localparam int BW   = $clog2(W);
   localparam logic [BW-1:0] LAST = BW'(W - 1);

   logic [DC_W-1:0] divcnt;
   logic [DC_W-1:0] mask;
   logic [W-1:0]    shreg;
   logic [W-1:0]    word_q;
   logic [BW-1:0]   bitcnt;
   logic            ready_q;
   logic            tick;
   logic            full;
   logic            sample;

   assign mask   = ~({DC_W{1'b1}} << div);
   assign tick   = run && ((divcnt & mask) == mask);
   assign full   = (bitcnt == LAST);
   assign sample = tick && in_valid && !(ready_q && full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divcnt  <= '0;
         shreg   <= '0;
         word_q  <= '0;
         bitcnt  <= '0;
         ready_q <= 1'b0;
      end else if (flush) begin
         divcnt  <= '0;
         shreg   <= '0;
         word_q  <= '0;
         bitcnt  <= '0;
         ready_q <= 1'b0;
      end else begin
         if (run) divcnt <= divcnt + 1'b1;
         if (take) ready_q <= 1'b0;
         if (sample) begin
            if (full) begin
               word_q  <= {shreg[W-2:0], in_bit};
               ready_q <= 1'b1;
               bitcnt  <= '0;
            end else begin
               shreg  <= {shreg[W-2:0], in_bit};
               bitcnt <= bitcnt + 1'b1;
            end
         end
      end
   end

   assign word  = word_q;
   assign ready = ready_q;
   assign step  = sample;
endmodule

// File: rtl/trng_recover.sv
module trng_recover #(
   parameter bit AUTO_RESET  = 1'b0,
   parameter int RST_CYCLES  = 8,
   parameter int AUTO_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enabled,
   input  logic fault,
   input  logic rst_set,
   input  logic rst_release,
   output logic rst_rd,
   output logic cur_seed,
   output logic seed_evt,
   output logic hold,
   output logic flush
);
   localparam int RB_W = $clog2(RST_CYCLES + 1);
   localparam logic [RB_W-1:0] RB_ONE = RB_W'(1);

   logic            req_q;
   logic [RB_W-1:0] busy_q;
   logic            cur_q;
   logic            rst_done;
   logic            auto_done;

   assign seed_evt = fault && enabled && !cur_q;
   assign rst_done = (busy_q == RB_ONE);

   generate
      if (AUTO_RESET) begin : g_auto
         localparam int AB_W = $clog2(AUTO_CYCLES + 1);
         logic [AB_W-1:0] acnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acnt <= '0;
            end else if (seed_evt) begin
               acnt <= AB_W'(AUTO_CYCLES);
            end else if (acnt != '0) begin
               acnt <= acnt - 1'b1;
            end
         end
         assign auto_done = (acnt == AB_W'(1));
      end else begin : g_cond
         assign auto_done = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         busy_q <= '0;
         cur_q  <= 1'b0;
      end else begin
         if (busy_q != '0) busy_q <= busy_q - 1'b1;
         if (rst_set) begin
            req_q <= 1'b1;
         end else if (rst_release && req_q) begin
            req_q  <= 1'b0;
            busy_q <= RB_W'(RST_CYCLES);
         end
         if (rst_done || auto_done) cur_q <= 1'b0;
         if (seed_evt) cur_q <= 1'b1;
      end
   end

   assign rst_rd   = req_q || (busy_q != '0);
   assign cur_seed = cur_q;
   assign hold     = rst_rd || cur_q;
   assign flush    = hold || seed_evt;
endmodule

// File: rtl/trng_clkmon.sv
module trng_clkmon #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             strobe,
   input  logic [CNT_W-1:0] limit,
   output logic             err,
   output logic             err_evt
);
   logic [CNT_W-1:0] gap_q;
   logic             err_q;
   logic             late;

   assign late    = (gap_q >= limit);
   assign err_evt = active && !strobe && late;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
         err_q <= 1'b0;
      end else if (!active || strobe) begin
         gap_q <= '0;
         err_q <= 1'b0;
      end else if (late) begin
         err_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assign err = err_q;
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
   import trng_pkg::*;
#(
   parameter int          ADDR_W      = 5,
   parameter int          DATA_W      = 32,
   parameter int          DIV_W       = 4,
   parameter int          GAP_W       = 16,
   parameter bit          HAS_LFSR    = 1'b1,
   parameter bit          AUTO_RESET  = 1'b0,
   parameter int          RST_CYCLES  = 8,
   parameter int          AUTO_CYCLES = 6,
   parameter logic [31:0] HEALTH_INIT = 32'h0000_0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ent_bit,
   input  logic              ent_valid,
   input  logic              seed_fault
);
   initial begin
      if (DATA_W != 32) $error("trng_ctrl: DATA_W must be 32");
      if (ADDR_W < 5) $error("trng_ctrl: ADDR_W must cover five address bits");
      if (DIV_W + CR_DIV_LO > 20) $error("trng_ctrl: divider field overlaps other fields");
      if (GAP_W > DATA_W) $error("trng_ctrl: GAP_W wider than health register");
      if (RST_CYCLES < 1 || AUTO_CYCLES < 1) $error("trng_ctrl: recovery cycles must be positive");
   end

   logic [2:0]        idx;
   logic              wr_any, rd_any;
   logic              wr_ctrl, wr_stat, wr_noise, wr_health, rd_data;
   logic              ctrl_en;
   logic              lock_q;
   logic [DATA_W-1:0] cfg_q;
   logic [NOISE_W-1:0] noise_q;
   logic [DATA_W-1:0] health_q;
   logic              flag_seed, flag_clk;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] ctrl_view, stat_view;

   logic              rst_set, rst_release, rst_rd;
   logic              cur_seed, seed_evt, hold, flush;
   logic              src_bit, src_valid, step;
   logic [DATA_W-1:0] word;
   logic              ready;
   logic              clk_err, clk_evt;
   logic              unused_addr;

   assign unused_addr = ^bus_addr[1:0];
   assign idx       = bus_addr[4:2];
   assign wr_any    = bus_sel && bus_wr;
   assign rd_any    = bus_sel && !bus_wr;
   assign wr_ctrl   = wr_any && (idx == IDX_CTRL);
   assign wr_stat   = wr_any && (idx == IDX_STAT);
   assign wr_noise  = wr_any && (idx == IDX_NOISE);
   assign wr_health = wr_any && (idx == IDX_HEALTH);
   assign rd_data   = rd_any && (idx == IDX_DATA);

   assign rst_set     = wr_ctrl && bus_wdata[CR_RST];
   assign rst_release = wr_ctrl && !bus_wdata[CR_RST];

   // control, configuration and lock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         lock_q  <= 1'b0;
         cfg_q   <= '0;
      end else if (wr_ctrl) begin
         ctrl_en <= bus_wdata[CR_EN];
         if (bus_wdata[CR_LOCK]) lock_q <= 1'b1;
         if (bus_wdata[CR_RST] && !lock_q) cfg_q <= bus_wdata & CFG_MASK;
      end
   end

   // auxiliary registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noise_q  <= '0;
         health_q <= HEALTH_INIT;
      end else begin
         if (wr_noise)  noise_q  <= bus_wdata[NOISE_W-1:0];
         if (wr_health) health_q <= bus_wdata;
      end
   end

   // sticky flags: set by events, cleared by a written zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_seed <= 1'b0;
         flag_clk  <= 1'b0;
      end else begin
         flag_seed <= (flag_seed && !(wr_stat && !bus_wdata[SR_SEED_FLG])) || seed_evt;
         flag_clk  <= (flag_clk  && !(wr_stat && !bus_wdata[SR_CLK_FLG]))  || clk_evt;
      end
   end

   trng_recover #(
      .AUTO_RESET (AUTO_RESET),
      .RST_CYCLES (RST_CYCLES),
      .AUTO_CYCLES(AUTO_CYCLES)
   ) u_recover (
      .clk        (clk),
      .rst_n      (rst_n),
      .enabled    (ctrl_en),
      .fault      (seed_fault),
      .rst_set    (rst_set),
      .rst_release(rst_release),
      .rst_rd     (rst_rd),
      .cur_seed   (cur_seed),
      .seed_evt   (seed_evt),
      .hold       (hold),
      .flush      (flush)
   );

   trng_source #(
      .HAS_LFSR(HAS_LFSR)
   ) u_source (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_int  (noise_q[NOISE_INT_SRC]),
      .ext_bit  (ent_bit),
      .ext_valid(ent_valid),
      .step     (step),
      .bit_o    (src_bit),
      .valid_o  (src_valid)
   );

   trng_gather #(
      .W    (DATA_W),
      .DIV_W(DIV_W)
   ) u_gather (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_en && !hold),
      .flush   (flush),
      .div     (cfg_q[CR_DIV_LO +: DIV_W]),
      .in_bit  (src_bit),
      .in_valid(src_valid),
      .take    (rd_data),
      .word    (word),
      .ready   (ready),
      .step    (step)
   );

   trng_clkmon #(
      .CNT_W(GAP_W)
   ) u_clkmon (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (ctrl_en && cfg_q[CR_CLKCHK]),
      .strobe (src_valid),
      .limit  (health_q[GAP_W-1:0]),
      .err    (clk_err),
      .err_evt(clk_evt)
   );

   always_comb begin
      ctrl_view = cfg_q;
      ctrl_view[CR_EN]   = ctrl_en;
      ctrl_view[CR_RST]  = rst_rd;
      ctrl_view[CR_LOCK] = lock_q;
      stat_view = '0;
      stat_view[SR_RDY]      = ready;
      stat_view[SR_CLK_NOW]  = clk_err;
      stat_view[SR_SEED_NOW] = cur_seed;
      stat_view[SR_CLK_FLG]  = flag_clk;
      stat_view[SR_SEED_FLG] = flag_seed;
   end

   always_comb begin
      case (idx)
         IDX_CTRL:   rd_mux = ctrl_view;
         IDX_STAT:   rd_mux = stat_view;
         IDX_DATA:   rd_mux = cur_seed ? '0 : word;
         IDX_NOISE:  rd_mux = DATA_W'(noise_q);
         IDX_HEALTH: rd_mux = health_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_any) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk
   import trng_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 32,
   parameter bit AUTO_RESET = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              flag_seed,
   input logic              cur_seed,
   input logic              ready,
   input logic              lock_q,
   input logic              rst_rd
);
   logic stat_clear_seed;
   logic data_read;
   assign stat_clear_seed = bus_sel && bus_wr && (bus_addr[4:2] == IDX_STAT) && !bus_wdata[SR_SEED_FLG];
   assign data_read       = bus_sel && !bus_wr && (bus_addr[4:2] == IDX_DATA);

   // R10
   seed_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_seed) |-> $past(stat_clear_seed));

   // R7
   seed_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_seed |-> !ready);

   // R2
   take_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_read && ready) |=> !ready);

   // R5
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R6
   reset_done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_rd) |-> !ready);

   generate
      if (!AUTO_RESET) begin : g_cond
         // R8
         seed_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cur_seed) |-> $fell(rst_rd));
      end
   endgenerate
endmodule

bind trng_ctrl trng_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .AUTO_RESET(AUTO_RESET)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .flag_seed(flag_seed),
   .cur_seed (cur_seed),
   .ready    (ready),
   .lock_q   (lock_q),
   .rst_rd   (rst_rd)
);

// File: tb/trng_ctrl_test.sv
module trng_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                          A_NOISE = 5'h0C, A_HEALTH = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_c, rdata_a;
   logic        ent_bit = 1'b0, ent_valid = 1'b0, seed_fault = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [31:0] sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   trng_ctrl #(.AUTO_RESET(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_c),
      .ent_bit(ent_bit), .ent_valid(ent_valid), .seed_fault(seed_fault));

   trng_ctrl #(.AUTO_RESET(1'b1)) uut_auto (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .ent_bit(ent_bit), .ent_valid(ent_valid), .seed_fault(seed_fault));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] dc, output logic [31:0] da);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      dc = rdata_c; da = rdata_a;
   endtask

   task automatic expect2(input string tag, input logic [4:0] a,
                          input logic [31:0] ec, input logic [31:0] ea);
      logic [31:0] dc, da;
      rd(a, dc, da);
      chk({tag, " cond"}, dc, ec);
      chk({tag, " auto"}, da, ea);
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      sb_q.delete();
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic feed_bits(input logic [31:0] w, input int n);
      for (int i = 31; i > 31 - n; i--) begin
         @(negedge clk);
         ent_valid = 1'b1; ent_bit = w[i];
      end
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   // driver: supplies a word and queues it as the expected result
   task automatic drive_word(input logic [31:0] w);
      sb_q.push_back(w);
      feed_bits(w, 32);
   endtask

   // monitor: pulls a word from the data register and pops its expectation
   task automatic monitor_word(input string tag);
      logic [31:0] dc, da, e;
      rd(A_DATA, dc, da);
      e = (sb_q.size() > 0) ? sb_q.pop_front() : 32'hDEAD_BEEF;
      chk({tag, " cond"}, dc, e);
      chk({tag, " auto"}, da, e);
   endtask

   task automatic cond_reset(input logic [31:0] cfg);
      wr(A_CTRL, cfg | 32'h4000_0000);
      wr(A_CTRL, cfg & ~32'h4000_0000);
      idle(12);
   endtask

   initial begin
      logic [31:0] dc, da;
      apply_reset();

      // R1 reset values
      expect2("R1 ctrl", A_CTRL, 32'h0, 32'h0);
      expect2("R1 stat", A_STAT, 32'h0, 32'h0);
      expect2("R1 noise", A_NOISE, 32'h0, 32'h0);
      expect2("R1 health", A_HEALTH, 32'h40, 32'h40);

      // R13 disabled: bits are not collected
      feed_bits(32'hFFFF_FFFF, 32);
      expect2("R13 no ready while disabled", A_STAT, 32'h0, 32'h0);

      // R2 word assembly, ready, read clears ready
      wr(A_CTRL, 32'h0000_0004);
      drive_word(32'hA5C3_0F96);
      expect2("R2 ready set", A_STAT, 32'h1, 32'h1);
      monitor_word("R2 word 1");
      expect2("R2 ready cleared by read", A_STAT, 32'h0, 32'h0);
      drive_word(32'h1234_5678);
      monitor_word("R2 word 2");
      drive_word(32'h8000_0001);
      monitor_word("R2 word 3");

      // R4 configuration only with the reset bit
      wr(A_CTRL, 32'h0002_0004);
      expect2("R4 cfg ignored without reset bit", A_CTRL, 32'h4, 32'h4);
      wr(A_CTRL, 32'h4002_0004);
      expect2("R4 cfg taken with reset bit", A_CTRL, 32'h4002_0004, 32'h4002_0004);
      // R6 reset bit stays up until the sequence completes
      wr(A_CTRL, 32'h0000_0004);
      expect2("R6 reset bit busy", A_CTRL, 32'h4002_0004, 32'h4002_0004);
      idle(12);
      expect2("R6 reset bit self-clears", A_CTRL, 32'h0002_0004, 32'h0002_0004);

      // R3 divider exponent 2: one bit every 4 cycles
      @(negedge clk);
      ent_valid = 1'b1; ent_bit = 1'b1;
      idle(100);
      expect2("R3 not ready after ~100 cycles", A_STAT, 32'h0, 32'h0);
      idle(40);
      expect2("R3 ready after ~140 cycles", A_STAT, 32'h1, 32'h1);
      ent_valid = 1'b0;
      expect2("R3 word", A_DATA, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      // R6 partial word discarded by conditional reset
      cond_reset(32'h0000_0004);
      feed_bits(32'hFFFF_FFFF, 20);
      cond_reset(32'h0000_0004);
      expect2("R6 nothing ready after flush", A_STAT, 32'h0, 32'h0);
      drive_word(32'h0F0F_3C3C);
      monitor_word("R6 clean word after flush");

      // R7 seed fault
      feed_bits(32'h5555_AAAA, 32);
      @(negedge clk); seed_fault = 1'b1;
      @(negedge clk); seed_fault = 1'b0;
      expect2("R7 fault flags", A_STAT, 32'h44, 32'h44);
      expect2("R7 data reads zero", A_DATA, 32'h0, 32'h0);
      idle(20);
      // R8 cond keeps current fault, R9 auto clears it
      expect2("R8/R9 after wait", A_STAT, 32'h44, 32'h40);
      feed_bits(32'hC001_D00D, 32);
      expect2("R7/R9 collection halted vs resumed", A_STAT, 32'h44, 32'h41);
      cond_reset(32'h0000_0004);
      expect2("R8 cleared by conditional reset", A_STAT, 32'h40, 32'h40);
      // R10 flag clearing
      wr(A_STAT, 32'hFFFF_FFFF);
      expect2("R10 write one keeps flag", A_STAT, 32'h40, 32'h40);
      wr(A_STAT, 32'h0);
      expect2("R10 write zero clears flag", A_STAT, 32'h0, 32'h0);
      drive_word(32'h7E57_0001);
      monitor_word("R8/R9 generation resumed");

      // R11 clock error detection
      cond_reset(32'h0000_0024);
      wr(A_HEALTH, 32'h0000_0010);
      idle(30);
      expect2("R11 clock error raised", A_STAT, 32'h22, 32'h22);
      @(negedge clk); ent_valid = 1'b1;
      @(negedge clk); ent_valid = 1'b0;
      expect2("R11 strobe clears current error", A_STAT, 32'h20, 32'h20);
      wr(A_STAT, 32'h0);
      expect2("R10 clock flag cleared", A_STAT, 32'h0, 32'h0);
      cond_reset(32'h0000_0004);
      idle(40);
      expect2("R11 no error with detection off", A_STAT, 32'h0, 32'h0);

      // R12 noise register width and internal source
      wr(A_NOISE, 32'hFFFF_FFFF);
      expect2("R12 noise mask", A_NOISE, 32'h0003_FFFF, 32'h0003_FFFF);
      idle(40);
      expect2("R12 internal source fills word", A_STAT, 32'h1, 32'h1);
      rd(A_DATA, dc, da);
      chk("R12 internal word nonzero cond", {31'b0, dc != 0}, 32'h1);
      chk("R12 internal word nonzero auto", {31'b0, da != 0}, 32'h1);
      wr(A_NOISE, 32'h0);

      // R5 lock
      apply_reset();
      wr(A_CTRL, 32'hC003_0004);
      expect2("R5 lock with cfg", A_CTRL, 32'hC003_0004, 32'hC003_0004);
      wr(A_CTRL, 32'h0000_0004);
      idle(12);
      expect2("R5 locked after release", A_CTRL, 32'h8003_0004, 32'h8003_0004);
      wr(A_CTRL, 32'h4000_0024);
      expect2("R5 cfg frozen", A_CTRL, 32'hC003_0004, 32'hC003_0004);
      wr(A_CTRL, 32'h0000_0004);
      idle(12);
      expect2("R5 lock survives zero write", A_CTRL, 32'h8003_0004, 32'h8003_0004);
      apply_reset();
      expect2("R5/R1 reset clears lock", A_CTRL, 32'h0, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule